// File: doc/BRIEF.md
# Peripheral Bus Clock Divider

This block derives a peripheral bus timing reference from the system clock by integer division. The output is a one-cycle strobe, `pb_tick`, issued once per peripheral period. Downstream logic uses it as a clock enable on the system clock. The ratio is held as "ratio minus one" in a 7-bit field, so ratios run from 1 to 128. A field value of 0 holds the strobe high on every cycle, which passes the system clock rate straight through.

Software changes the ratio with a two-sided handshake. It first waits for `ready`, then writes the new field. `ready` drops at once and comes back only when the new ratio is in force. At that point `ratio_rd` shows the ratio actually applied, so software can compare it with what it wrote. A change waits for the current output period to finish, so no period of odd length appears. A ratio write while `ready` is low is discarded. The write-enable strobes stand in for any chip-level write-protection sequence.

An enable bit, with its own write strobe and readback, gates the strobe. While the divider is disabled its period counter rests at zero, and a pending ratio takes effect on the next edge.

Top module: `pbus_clk_div`

## Requirements
- R1: After reset, `ready`=1, `enabled`=1, `ratio_rd`=1, and `pb_tick` pulses once every 2 cycles.
- R2: While enabled with field value N applied, `pb_tick` is high for one cycle out of every N+1 cycles.
- R3: With field value 0 applied and the divider enabled, `pb_tick` is high on every cycle.
- R4: A ratio write (`ratio_we`=1) sampled while `ready`=1 drives `ready` to 0 on the next cycle; `ratio_rd` keeps the old value until the change is applied.
- R5: A pending ratio is applied at the edge that ends the current output period. The old period completes at its full length. `ready` returns to 1 and `ratio_rd` shows the new field in the same cycle, and the next strobe follows N+1 cycles later.
- R6: A ratio write sampled while `ready`=0 is ignored; the field applied is the one written while `ready` was 1.
- R7: `en_we`=1 loads `en_wdata` into `enabled` on the next cycle, whatever the state of `ready`. While `enabled`=0, `pb_tick` stays 0.
- R8: While disabled, a pending ratio is applied on the edge after it was accepted, so `ready` is 0 for exactly one cycle.
- R9: The largest field value, 127, gives a period of 128 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ratio_we | input | 1 | Ratio field write strobe (already unlocked) |
| ratio_wdata | input | DIV_W | New ratio minus one |
| en_we | input | 1 | Enable bit write strobe |
| en_wdata | input | 1 | New enable value |
| ratio_rd | output | DIV_W | Ratio minus one currently applied |
| ready | output | 1 | High when a new ratio may be written |
| enabled | output | 1 | Enable bit readback |
| pb_tick | output | 1 | One-cycle strobe per peripheral period |

## Verification
The bench measures the spacing between strobes for directed field values 0, 1, 2, 5 and 127 and for 30 random fields. These runs separate an off-by-one in the stored ratio from a correct divide, and they expose the stuck-high case at field 0. A write placed in the middle of a long period checks that the old period keeps its full length and that the new spacing starts right after the edge where `ready` returns, which shows whether the change waits for the period boundary. Back-to-back writes, and writes made while the divider is disabled, check that a write during busy is dropped and that a disabled divider applies its pending ratio on the very next edge.

// File: rtl/pbdiv_pkg.sv
package pbdiv_pkg;
   localparam int unsigned PBDIV_DEF_W = 7;

   typedef enum logic {
      HS_IDLE = 1'b0,
      HS_PEND = 1'b1
   } pbdiv_hs_e;
endpackage

// File: rtl/pbdiv_enable.sv
module pbdiv_enable (
   input  logic clk,
   input  logic rst_n,
   input  logic en_we,
   input  logic en_wdata,
   output logic en_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en_q <= 1'b1;
      else if (en_we) en_q <= en_wdata;
   end
endmodule

// File: rtl/pbdiv_ratio_ctl.sv
module pbdiv_ratio_ctl #(
   parameter int unsigned DIV_W     = 7,
   parameter int unsigned RST_FIELD = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_stb,
   input  logic [DIV_W-1:0] wr_field,
   input  logic             period_end,
   input  logic             run,
   output logic [DIV_W-1:0] act_field,
   output logic             rdy
);
   import pbdiv_pkg::*;

   localparam logic [DIV_W-1:0] RST_VAL = DIV_W'(RST_FIELD);

   pbdiv_hs_e        hs_q;
   logic [DIV_W-1:0] pend_q;
   logic             take;
   logic             commit;

   assign take   = (hs_q == HS_IDLE) && wr_stb;
   assign commit = (hs_q == HS_PEND) && (period_end || !run);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_q      <= HS_IDLE;
         pend_q    <= RST_VAL;
         act_field <= RST_VAL;
      end else if (take) begin
         hs_q   <= HS_PEND;
         pend_q <= wr_field;
      end else if (commit) begin
         hs_q      <= HS_IDLE;
         act_field <= pend_q;
      end
   end

   assign rdy = (hs_q == HS_IDLE);
endmodule

// File: rtl/pbdiv_counter.sv
module pbdiv_counter #(
   parameter int unsigned DIV_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] limit,
   output logic             wrap
);
   logic [DIV_W-1:0] cnt_q;

   assign wrap = run && (cnt_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (!run || wrap)     cnt_q <= '0;
      else                       cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/pbus_clk_div.sv
module pbus_clk_div #(
   parameter int unsigned DIV_W     = pbdiv_pkg::PBDIV_DEF_W,
   parameter int unsigned RST_FIELD = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ratio_we,
   input  logic [DIV_W-1:0] ratio_wdata,
   input  logic             en_we,
   input  logic             en_wdata,
   output logic [DIV_W-1:0] ratio_rd,
   output logic             ready,
   output logic             enabled,
   output logic             pb_tick
);
   generate
      if (DIV_W < 1 || DIV_W > 16) begin : g_bad_width
         $error("pbus_clk_div: DIV_W must lie in 1..16");
      end
      if (RST_FIELD >= (1 << DIV_W)) begin : g_bad_reset
         $error("pbus_clk_div: RST_FIELD does not fit in DIV_W bits");
      end
   endgenerate

   logic             wrap;
   logic [DIV_W-1:0] act_field;

   pbdiv_enable u_enable (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_we    (en_we),
      .en_wdata (en_wdata),
      .en_q     (enabled)
   );

   pbdiv_ratio_ctl #(.DIV_W(DIV_W), .RST_FIELD(RST_FIELD)) u_ratio (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_stb     (ratio_we),
      .wr_field   (ratio_wdata),
      .period_end (wrap),
      .run        (enabled),
      .act_field  (act_field),
      .rdy        (ready)
   );

   pbdiv_counter #(.DIV_W(DIV_W)) u_count (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (enabled),
      .limit (act_field),
      .wrap  (wrap)
   );

   assign ratio_rd = act_field;
   assign pb_tick  = wrap;
endmodule

// File: rtl/pbus_clk_div_chk.sv
module pbus_clk_div_chk #(
   parameter int unsigned DIV_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ratio_we,
   input logic             en_we,
   input logic             en_wdata,
   input logic [DIV_W-1:0] ratio_rd,
   input logic             ready,
   input logic             enabled,
   input logic             pb_tick
);
   assert_busy_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && ratio_we) |=> !ready);

   assert_ratio_moves_with_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ratio_rd) |-> $rose(ready));

   assert_gap_after_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pb_tick && ready && ratio_rd != '0) |=> !pb_tick);

   assert_pass_through_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (enabled && ready && ratio_rd == '0) |-> pb_tick);

   assert_no_tick_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !enabled |-> !pb_tick);

   assert_enable_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      en_we |=> (enabled == $past(en_wdata)));

   assert_disabled_apply_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!enabled && !ready && !en_we) |=> ready);
endmodule

bind pbus_clk_div pbus_clk_div_chk #(.DIV_W(DIV_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ratio_we (ratio_we),
   .en_we    (en_we),
   .en_wdata (en_wdata),
   .ratio_rd (ratio_rd),
   .ready    (ready),
   .enabled  (enabled),
   .pb_tick  (pb_tick)
);

// File: tb/pbus_clk_div_bench.sv
`timescale 1ns/1ps
module pbus_clk_div_bench;
   localparam int W = 7;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ratio_we = 1'b0;
   logic [W-1:0] ratio_wdata = '0;
   logic         en_we = 1'b0;
   logic         en_wdata = 1'b0;
   logic [W-1:0] ratio_rd;
   logic         ready;
   logic         enabled;
   logic         pb_tick;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   pbus_clk_div u_pbus_clk_div (
      .clk(clk), .rst_n(rst_n), .ratio_we(ratio_we), .ratio_wdata(ratio_wdata),
      .en_we(en_we), .en_wdata(en_wdata), .ratio_rd(ratio_rd), .ready(ready),
      .enabled(enabled), .pb_tick(pb_tick)
   );

   function automatic int exp_period(input int field);
      return field + 1;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   always @(posedge clk) begin
      if (!done && cyc > 150000) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=<150000", cyc);
         finish_run();
      end
   end

   task automatic write_ratio(input int v);
      ratio_we    = 1'b1;
      ratio_wdata = W'(v);
      @(negedge clk);
      ratio_we    = 1'b0;
   endtask

   task automatic write_en(input bit v);
      en_we    = 1'b1;
      en_wdata = v;
      @(negedge clk);
      en_we    = 1'b0;
   endtask

   task automatic wait_ready();
      while (!ready) @(negedge clk);
   endtask

   task automatic next_tick(output int t);
      do @(negedge clk); while (!pb_tick);
      t = cyc;
   endtask

   task automatic period(output int p);
      int a, b;
      next_tick(a);
      next_tick(b);
      p = b - a;
   endtask

   task automatic set_and_check(input int v, input string req);
      int old, p;
      old = int'(ratio_rd);
      write_ratio(v);
      chk("R4 ready low after write", int'(ready), 0);
      chk("R4 readback holds old", int'(ratio_rd), old);
      wait_ready();
      chk({req, " readback"}, int'(ratio_rd), v);
      period(p);
      chk({req, " period"}, p, exp_period(v));
   endtask

   initial begin
      int p, t0, t1, t2, n, seed;
      seed = 32'h5eed_0101;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 ready", int'(ready), 1);
      chk("R1 enabled", int'(enabled), 1);
      chk("R1 ratio_rd", int'(ratio_rd), 1);
      period(p);
      chk("R1 period", p, 2);

      // R2 / R3 / R9 directed values
      set_and_check(0, "R3");
      set_and_check(1, "R2");
      set_and_check(2, "R2");
      set_and_check(5, "R2");
      set_and_check(127, "R9");

      // R5 change mid-period: old period completes, new starts at boundary
      set_and_check(9, "R2");
      next_tick(t0);
      repeat (3) @(negedge clk);
      write_ratio(2);
      chk("R5 busy", int'(ready), 0);
      next_tick(t1);
      chk("R5 old period full", t1 - t0, 10);
      chk("R5 old readback at last tick", int'(ratio_rd), 9);
      @(negedge clk);
      chk("R5 ready back", int'(ready), 1);
      chk("R5 new readback", int'(ratio_rd), 2);
      next_tick(t2);
      chk("R5 first new period", t2 - t1, 3);

      // R6 write during busy ignored
      write_ratio(4);
      write_ratio(6);
      wait_ready();
      chk("R6 readback", int'(ratio_rd), 4);
      period(p);
      chk("R6 period", p, 5);

      // R7 disable: no ticks
      write_en(1'b0);
      chk("R7 enabled readback", int'(enabled), 0);
      n = 0;
      repeat (20) begin
         @(negedge clk);
         if (pb_tick) n++;
      end
      chk("R7 no ticks while disabled", n, 0);

      // R8 pending applies next edge while disabled
      write_ratio(3);
      chk("R8 busy one cycle", int'(ready), 0);
      @(negedge clk);
      chk("R8 ready after one cycle", int'(ready), 1);
      chk("R8 readback", int'(ratio_rd), 3);
      chk("R7 still no tick", int'(pb_tick), 0);
      write_en(1'b1);
      chk("R7 enabled again", int'(enabled), 1);
      period(p);
      chk("R7 period after enable", p, 4);

      // R7 enable write accepted while ready low
      write_ratio(20);
      write_en(1'b0);
      chk("R7 enable write while busy", int'(enabled), 0);
      @(negedge clk);
      write_en(1'b1);
      wait_ready();
      chk("R7 readback after busy", int'(ratio_rd), 20);

      // random fields
      for (int i = 0; i < 30; i++) begin
         int v;
         v = int'($urandom % 128);
         set_and_check(v, "R2 random");
      end

      finish_run();
   end
endmodule